// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Set-Less-Than and Zero Flag

This block is a purely combinational integer ALU built as a ripple chain of identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder. Either operand can be inverted inside the slice before it reaches these gates. A four-way selector in each slice picks the slice output from the AND result, the OR result, the adder sum, or a comparison input.

Three controls steer the datapath: an A-invert bit, a B-negate bit and a two-bit function select. B-negate also feeds the carry into the lowest slice, so subtraction is formed as A + ~B + 1. NOR comes from inverting both operands and taking their AND. Set-less-than routes the top slice's adder sum bit back into the lowest slice's comparison input; all other comparison inputs are zero.

The block also provides three flags. The zero flag is high when every result bit is zero. A branch on equal or not-equal runs a subtraction and reads only this flag. Overflow and carry-out are taken from the carries around the sign bit.

Top module: `slice_alu`

## Requirements
- R1: With controls {ainv,bneg,fsel} = 0,0,00 the result is the bitwise AND of A and B.
- R2: With controls 0,0,01 the result is the bitwise OR of A and B.
- R3: With controls 0,0,10 the result is (A + B) mod 2^W, and carry-out is bit W of the unsigned sum.
- R4: With controls 0,1,10 the result is (A - B) mod 2^W. Carry-out is the carry from A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R5: With controls 1,1,00 the result is the bitwise NOR of A and B.
- R6: With controls 0,1,11 result bit 0 equals bit W-1 of (A - B) mod 2^W and all higher bits are 0. No overflow correction is applied, so the answer is wrong for signed pairs whose difference overflows.
- R7: The zero flag is 1 exactly when all W result bits are 0, whatever operation is selected.
- R8: For add and subtract, the overflow flag is 1 exactly when the carry into the sign bit differs from the carry out of it. For add this means two operands of equal sign give a sum of the other sign. For subtract it means operands of differing sign give a difference whose sign differs from A.
- R9: An equality test uses the subtract controls: the zero flag is 1 if and only if A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| ainv_i | input | 1 | Invert A inside every slice |
| bneg_i | input | 1 | Invert B inside every slice and force carry-in of slice 0 |
| fsel_i | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 comparison input |
| res_o | output | W | Result word |
| zero_o | output | 1 | All result bits are zero |
| ovf_o | output | 1 | Signed overflow (carry into sign bit differs from carry out) |
| cout_o | output | 1 | Carry out of the top slice |

## Verification
Set-less-than and signed overflow happen at the same time whenever a subtraction's sign bit is corrupted. The bench provokes this with operand pairs such as the most negative value minus one, and the most positive value minus minus-one. In those cases the reference expects the uncorrected sign bit in bit 0 and the overflow flag raised on the same vector. The zero flag and the equality test also coincide on every subtraction of equal operands. On those vectors the bench judges the zero flag, the carry-out and the result together.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
   typedef enum logic [1:0] {
      FSEL_AND  = 2'b00,
      FSEL_OR   = 2'b01,
      FSEL_SUM  = 2'b10,
      FSEL_LESS = 2'b11
   } fsel_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import slice_alu_pkg::*;
#(
   parameter int INV_STYLE = 0
) (
   input  logic       a,
   input  logic       b,
   input  logic       ainv,
   input  logic       bneg,
   input  logic       cin,
   input  logic       less,
   input  logic [1:0] fsel,
   output logic       res,
   output logic       sum,
   output logic       cout
);
   logic a_eff, b_eff;

   generate
      if (INV_STYLE == 0) begin : g_mux_inv
         assign a_eff = ainv ? ~a : a;
         assign b_eff = bneg ? ~b : b;
      end else begin : g_xor_inv
         assign a_eff = a ^ ainv;
         assign b_eff = b ^ bneg;
      end
   endgenerate

   assign sum  = a_eff ^ b_eff ^ cin;
   assign cout = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));

   always_comb begin
      case (fsel_e'(fsel))
         FSEL_AND: res = a_eff & b_eff;
         FSEL_OR:  res = a_eff | b_eff;
         FSEL_SUM: res = sum;
         default:  res = less;
      endcase
   end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int W = 32
) (
   input  logic [W-1:0] word,
   output logic         zero
);
   assign zero = ~|word;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import slice_alu_pkg::*;
#(
   parameter int W         = 32,
   parameter int INV_STYLE = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         ainv_i,
   input  logic         bneg_i,
   input  logic [1:0]   fsel_i,
   output logic [W-1:0] res_o,
   output logic         zero_o,
   output logic         ovf_o,
   output logic         cout_o
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("slice_alu: W must be at least 2");
      end
      if (INV_STYLE != 0 && INV_STYLE != 1) begin : g_bad_style
         $error("slice_alu: INV_STYLE must be 0 or 1");
      end
   endgenerate

   logic [W:0]   carry;
   logic [W-1:0] sum_w;
   logic         set_w;

   assign carry[0] = bneg_i;
   assign set_w    = sum_w[MSB];

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_slice
         logic less_in;
         if (i == 0) begin : g_lsb
            assign less_in = set_w;
         end else begin : g_upper
            assign less_in = 1'b0;
         end
         alu_bit_slice #(.INV_STYLE(INV_STYLE)) u_slice (
            .a    (a_i[i]),
            .b    (b_i[i]),
            .ainv (ainv_i),
            .bneg (bneg_i),
            .cin  (carry[i]),
            .less (less_in),
            .fsel (fsel_i),
            .res  (res_o[i]),
            .sum  (sum_w[i]),
            .cout (carry[i+1])
         );
      end
   endgenerate

   alu_zero_detect #(.W(W)) u_zero (
      .word (res_o),
      .zero (zero_o)
   );

   assign cout_o = carry[W];
   assign ovf_o  = carry[W] ^ carry[MSB];

   always_comb begin
      if (!ainv_i && !bneg_i && fsel_i == FSEL_AND) begin
         a_r1_and_word: assert (res_o == (a_i & b_i))
            else $error("R1 AND result mismatch");
      end
      if (!ainv_i && bneg_i && fsel_i == FSEL_LESS) begin
         a_r6_slt_upper_zero: assert (res_o[MSB:1] == '0)
            else $error("R6 upper bits not zero");
      end
      if (!ainv_i && !bneg_i && fsel_i == FSEL_SUM && ovf_o) begin
         a_r8_add_ovf_signs: assert (a_i[MSB] == b_i[MSB] && res_o[MSB] != a_i[MSB])
            else $error("R8 overflow without sign flip");
      end
      if (!ainv_i && bneg_i && fsel_i == FSEL_SUM && a_i == b_i) begin
         a_r9_equal_zero: assert (zero_o)
            else $error("R9 equal operands not zero");
         a_r4_equal_cout: assert (cout_o)
            else $error("R4 equal operands without carry");
      end
   end
endmodule

// File: tb/tb_slice_alu.sv
module tb_slice_alu;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic         ainv, bneg;
   logic [1:0]   fsel;
   logic [W-1:0] res;
   logic         zero, ovf, cout;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   slice_alu #(.W(W)) dut (
      .a_i(a), .b_i(b), .ainv_i(ainv), .bneg_i(bneg), .fsel_i(fsel),
      .res_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
      end
   endtask

   // op index: 0 AND, 1 OR, 2 ADD, 3 SUB, 4 NOR, 5 SLT
   task automatic run_op(input int op, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W:0]   wide;
      logic [W-1:0] r;
      logic         c, v;
      string        tag;
      @(posedge clk);
      #2;
      a = x; b = y;
      c = 1'b0; v = 1'b0; r = '0;
      case (op)
         0: begin ainv = 0; bneg = 0; fsel = 2'b00; r = x & y;    tag = "R1"; end
         1: begin ainv = 0; bneg = 0; fsel = 2'b01; r = x | y;    tag = "R2"; end
         2: begin ainv = 0; bneg = 0; fsel = 2'b10;
                  wide = {1'b0, x} + {1'b0, y}; r = wide[W-1:0]; c = wide[W];
                  v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); tag = "R3"; end
         3: begin ainv = 0; bneg = 1; fsel = 2'b10;
                  r = x - y; c = (x >= y);
                  v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); tag = "R4"; end
         4: begin ainv = 1; bneg = 1; fsel = 2'b00; r = ~(x | y); tag = "R5"; end
         default: begin ainv = 0; bneg = 1; fsel = 2'b11;
                  wide[W-1:0] = x - y; r = '0; r[0] = wide[W-1];
                  c = (x >= y);
                  v = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]); tag = "R6"; end
      endcase
      @(negedge clk);
      chk(tag, res, r);
      chk("R7 zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (r == '0)});
      if (op == 2 || op == 3 || op == 5) begin
         chk(op == 2 ? "R3 cout" : "R4 cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, c});
         chk("R8 ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, v});
      end
      if (op == 3)
         chk("R9 equality", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (x == y)});
   endtask

   logic [W-1:0] edges [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h8000_0001, 32'h5555_AAAA, 32'h0000_FFFF};

   initial begin
      a = '0; b = '0; ainv = 0; bneg = 0; fsel = 2'b00;
      @(negedge clk);
      // reset-free block: all-zero inputs give zero result and zero flag (R1, R7)
      chk("R1 idle", res, '0);
      chk("R7 idle", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
      // SLT with overflowing subtraction: most negative minus one reports not-less (R6)
      run_op(5, 32'h8000_0000, 32'h0000_0001);
      run_op(5, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run_op(2, 32'h7FFF_FFFF, 32'h1);
      run_op(2, 32'hFFFF_FFFF, 32'h1);
      run_op(3, 32'h1234_5678, 32'h1234_5678);
      run_op(3, 32'h8000_0000, 32'h1);
      for (int op = 0; op < 6; op++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run_op(op, edges[i], edges[j]);
      for (int n = 0; n < 600; n++) begin
         logic [W-1:0] x, y;
         x = $urandom;
         y = (n % 7 == 0) ? x : $urandom;
         run_op(n % 6, x, y);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule